// File: doc/BRIEF.md
# Split-Phase Truncating Address Multiplier

This block multiplies two 32-bit integers and returns only the low 32 bits of the product. Any bits above bit 31 are dropped, and no flag reports that they were lost. The two operands share one input bus and arrive in consecutive cycles. A single strobe marks the cycle that carries the first operand, which is the multiplicand. The second operand, the multiplier, follows on the next cycle.

To halve the partial-product logic, the multiplicand is split into its even-indexed and odd-indexed bits. The even bits are multiplied against the held multiplier in one cycle. The odd bits are multiplied against the same held value one cycle later. The odd result is then added to the registered even result.

The output bus is shared with a program-counter value. In the single cycle that carries a product, the product is driven onto the bus. In every other cycle the bus carries the program-counter input unchanged. A second output gives the program-counter input delayed by one clock.

Top module: `addr_split_mul`

## Requirements
- R1: In its result cycle, `mul_bus` equals the low 32 bits of (multiplicand × multiplier), with both operands taken as unsigned. Higher product bits are discarded and nothing signals their loss.
- R2: The multiplicand is the `opnd_in` value in the cycle where `go` is 1. The multiplier is the `opnd_in` value in the cycle that follows.
- R3: `res_valid` is 1 in exactly one cycle per strobe: the fourth cycle after the strobe cycle. It is 0 in every other cycle.
- R4: In every cycle where `res_valid` is 0, `mul_bus` equals `pc_in` of that same cycle.
- R5: `pc_late` equals the `pc_in` value of the previous clock cycle.
- R6: Strobes spaced two cycles apart each give a correct product. A strobe may never come in the cycle right after another strobe.
- R7: While `rst_n` is low, `res_valid` is 0 and `pc_late` is 0.
- R8: `opnd_in` values outside the two operand cycles of a multiply have no effect on any product.
- R9: Multiplicands that have only even bits set (0x55555555) or only odd bits set (0xAAAAAAAA) give correct products, as do all-ones and zero operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start strobe; it marks the multiplicand cycle |
| opnd_in | input | 32 | Shared operand bus |
| pc_in | input | 32 | Program-counter value to pass through |
| mul_bus | output | 32 | Shared result bus: the product when res_valid is 1, otherwise pc_in |
| res_valid | output | 1 | Marks the cycle that carries a product |
| pc_late | output | 32 | pc_in delayed by one clock |

## Verification
The bench puts random values on the operand bus in every cycle outside the two operand cycles. A design that sampled the multiplier one cycle late, or sampled the multiplicand again, would return the product of that noise. Multiplicands of 0x55555555 and 0xAAAAAAAA each use only one half of the split. A design that dropped either half, or added the odd half at the wrong weight, would fail on these. Strobes spaced exactly two cycles apart overlap the odd phase of one multiply with the operand capture of the next. A design that kept the odd bits in the shared operand register would mix the two operations. The bench also checks the bus in every cycle without a result, because a result gate one cycle early or late would put a product where the program-counter value belongs.

// File: rtl/addr_split_mul.sv
module addr_split_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] opnd_in,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] mul_bus,
  output logic         res_valid,
  output logic [W-1:0] pc_late
);
  localparam int STAGES = 4;

  logic [STAGES-1:0] go_sr;
  logic [W-1:0] mcand_r, odd_r, mplier_r, even_r, prod_r;
  logic [W-1:0] even_pp, odd_pp;

  always_comb begin
    even_pp = '0;
    for (int k = 0; k < W; k += 2)
      if (mcand_r[k]) even_pp = even_pp + (mplier_r << k);
  end

  always_comb begin
    odd_pp = '0;
    for (int k = 1; k < W; k += 2)
      if (odd_r[k]) odd_pp = odd_pp + (mplier_r << k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_sr    <= '0;
      mcand_r  <= '0;
      odd_r    <= '0;
      mplier_r <= '0;
      even_r   <= '0;
      prod_r   <= '0;
      pc_late  <= '0;
    end else begin
      go_sr   <= {go_sr[STAGES-2:0], go};
      pc_late <= pc_in;
      if (go) mcand_r <= opnd_in;
      if (go_sr[0]) begin
        mplier_r <= opnd_in;
        odd_r    <= mcand_r;
      end
      if (go_sr[1]) even_r <= even_pp;
      if (go_sr[2]) prod_r <= even_r + odd_pp;
    end
  end

  assign res_valid = go_sr[STAGES-1];
  assign mul_bus   = res_valid ? prod_r : pc_in;
endmodule

// File: rtl/addr_split_mul_chk.sv
module addr_split_mul_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         go,
  input logic [W-1:0] opnd_in,
  input logic [W-1:0] pc_in,
  input logic [W-1:0] mul_bus,
  input logic         res_valid,
  input logic [W-1:0] pc_late
);
  logic [W-1:0]   ak_c, e1, e2, e3;
  logic [2*W-1:0] full;
  logic           g1, v1, v2, v3, armed;

  assign full = {{W{1'b0}}, ak_c} * {{W{1'b0}}, opnd_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ak_c <= '0; e1 <= '0; e2 <= '0; e3 <= '0;
      g1 <= 1'b0; v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      g1 <= go;
      if (go) ak_c <= opnd_in;
      v1 <= g1; v2 <= v1; v3 <= v2;
      if (g1) e1 <= full[W-1:0];
      e2 <= e1; e3 <= e2;
    end
  end

  assert_valid_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == v3);
  assert_low_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    v3 |-> mul_bus == e3);
  assert_strobe_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  assert_pc_delay_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    pc_late == $past(pc_in));
  always_comb
    if (!rst_n) assert_reset_quiet_R7: assert (!res_valid && pc_late == '0);
endmodule

bind addr_split_mul addr_split_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .opnd_in(opnd_in), .pc_in(pc_in),
  .mul_bus(mul_bus), .res_valid(res_valid), .pc_late(pc_late)
);

// File: tb/addr_split_mul_tb.sv
`timescale 1ns/1ps
module addr_split_mul_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [31:0] opnd_in = '0, pc_in = '0;
  logic [31:0] mul_bus, pc_late;
  logic        res_valid;

  int checks = 0, fails = 0;
  logic [31:0] rng = 32'h1234_5678;
  logic [31:0] ak_s [512];
  logic [31:0] aj_s [512];
  logic [31:0] prev_pc;
  bit          prev_ok = 0;

  always #4 clk = ~clk;

  addr_split_mul u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .opnd_in(opnd_in), .pc_in(pc_in),
    .mul_bus(mul_bus), .res_valid(res_valid), .pc_late(pc_late)
  );

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pick(int mode, int i, output logic [31:0] a, output logic [31:0] b);
    logic [31:0] ca [8] = '{32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h5555_5555,
                             32'hAAAA_AAAA, 32'h8000_0000, 32'h1, 32'hAAAA_AAAA};
    logic [31:0] cb [8] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h3,
                             32'hFFFF_FFFF, 32'h2, 32'hDEAD_BEEF, 32'h5555_5555};
    case (mode)
      0: begin a = ca[i % 8]; b = cb[i % 8]; end
      1: begin a = 32'(i / 16); b = 32'(i % 16); end
      default: begin rng = nxt(rng); a = rng; rng = nxt(rng); b = rng; end
    endcase
  endtask

  task automatic stream(int n, int gap, int mode, string req);
    for (int c = 0; c <= n * gap + 6; c++) begin
      int idx = c / gap, ph = c % gap;
      int r = c - 4;
      @(negedge clk);
      rng = nxt(rng); pc_in = rng;
      rng = nxt(rng); opnd_in = rng;
      go = 1'b0;
      if (idx < n && ph == 0) begin
        pick(mode, idx, ak_s[idx], aj_s[idx]);
        go = 1'b1; opnd_in = ak_s[idx];
      end else if (idx < n && ph == 1) opnd_in = aj_s[idx];
      #1;
      if (r >= 0 && r % gap == 0 && r / gap < n) begin
        logic [63:0] p = {32'h0, ak_s[r/gap]} * {32'h0, aj_s[r/gap]};
        chk({"R3 valid ", req}, {31'h0, res_valid}, 32'h1);
        chk({"R1 R2 R8 product ", req}, mul_bus, p[31:0]);
      end else begin
        chk({"R3 idle ", req}, {31'h0, res_valid}, 32'h0);
        chk({"R4 pass ", req}, mul_bus, pc_in);
      end
      if (prev_ok) chk("R5 pc delay", pc_late, prev_pc);
      prev_pc = pc_in; prev_ok = 1;
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) begin
          @(negedge clk);
          rng = nxt(rng); pc_in = rng; opnd_in = ~rng; #1;
          chk("R7 reset valid", {31'h0, res_valid}, 32'h0);
          chk("R7 reset pc_late", pc_late, 32'h0);
          chk("R4 reset pass", mul_bus, pc_in);
        end
        @(negedge clk); rst_n = 1'b1;
        prev_pc = pc_in; prev_ok = 1;
        stream(16, 2, 0, "R9 corners gap2 R6");
        stream(16, 3, 0, "R9 corners gap3");
        stream(256, 2, 1, "sweep4x4 R6");
        stream(100, 2, 2, "random gap2 R6");
        stream(60, 5, 2, "random gap5");
      end
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual expired expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule